// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

This block moves data in both directions between an A port and a B port. Each port is split into two independent 8-bit channels. In each channel, each direction has three controls. A capture strobe stores the value present on the source port. A select chooses whether the destination port receives the live source value or the stored word. An output enable decides whether the destination port is driven at all. The enable that drives the B port is active high. The enable that drives the A port is active low.

Tri-state pins are modelled as three vectors per port: an input, an output and a per-bit output enable. Each capture strobe is sampled on the system clock, and a low-to-high change of the strobe loads the register. Each register captures the resolved bus value. When the block itself drives a port, that is the value it drives, so one word can be copied into both registers. Two settings would let each port feed the other live and form a combinational loop. In that case the block raises a per-channel error flag and drives neither port. A synchronous active-high reset clears the stored words and holds every output enable low.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A register loads only on a clock edge where its capture strobe samples 1 and sampled 0 at the previous edge. The A register loads the resolved A bus and the B register loads the resolved B bus. The new value is visible after that edge. A strobe held high, or high on the first edge after reset, loads nothing.
- R2: Without such a strobe edge, a stored word keeps its value whatever the data inputs and enables do.
- R3: `en_ab`=1 sets every bit of the channel's `b_oe`. `en_ba_n`=0 sets every bit of the channel's `a_oe`. Both hold only outside reset and outside the loop case of R8.
- R4: With `sel_ab`=0, `b_out` carries the live A bus; with `sel_ab`=1 it carries the stored A word. `sel_ba` selects the same way for `a_out` from the B side.
- R5: With `en_ab`=0 and `en_ba_n`=1, both enable vectors of the channel are zero. Any undriven output vector reads zero.
- R6: A register whose port the block is driving captures the driven value. Example: `en_ab`=1, `sel_ab`=0 and a B strobe edge load the A input word into the B register.
- R7: With both directions enabled and both selects at 1, the stored A word appears on `b_out` and the stored B word on `a_out` in the same cycle.
- R8: With `en_ab`=1, `en_ba_n`=0 and both selects at 0, `loop_err` is 1 and both enable vectors of the channel are zero. Captures then take the raw input vectors.
- R9: While `rst` is 1, all enable vectors and `loop_err` are zero. The first edge with `rst` at 1 clears both stored words of every channel.
- R10: Activity on one channel leaves the other channel's outputs and stored words unchanged.
- R11: When both strobes of a channel rise at the same edge, each register takes the bus value from before that edge. With both directions enabled and both selects at 1, this swaps the two stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | A port input, channel c in bits [8c+7:8c] |
| a_out | output | 16 | Value driven onto the A port |
| a_oe | output | 16 | Per-bit drive enable for the A port |
| b_in | input | 16 | B port input |
| b_out | output | 16 | Value driven onto the B port |
| b_oe | output | 16 | Per-bit drive enable for the B port |
| cap_ab | input | 2 | Per-channel strobe that loads the A register |
| cap_ba | input | 2 | Per-channel strobe that loads the B register |
| sel_ab | input | 2 | Per-channel B-port source: 0 live A, 1 stored A |
| sel_ba | input | 2 | Per-channel A-port source: 0 live B, 1 stored B |
| en_ab | input | 2 | Per-channel B-port drive enable, active high |
| en_ba_n | input | 2 | Per-channel A-port drive enable, active low |
| loop_err | output | 2 | Per-channel flag for the forbidden loop setting |

## Verification
Capture and output selection can meet in one cycle. A register can load while its own stored word is driving the opposite port, or while the block drives the port it samples. The table provokes both cases with single-strobe rows where the block drives the captured port, and with a row that fires both strobes under the swap setting. Each capture is judged by a readback that places both stored words on the outputs and compares them with a model that uses the pre-edge bus values. A further row fires both strobes in the loop setting, so that flagging and capture of the raw inputs happen in the same cycle.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

  // Per-channel direction controls as seen by one lane.
  typedef struct packed {
    logic en_ab;    // drive B port, active high
    logic en_ba_n;  // drive A port, active low
    logic sel_ab;   // B source: 0 live A, 1 stored A
    logic sel_ba;   // A source: 0 live B, 1 stored B
  } lane_ctrl_t;

  // Both ports fed live from each other: no stable value exists.
  function automatic logic is_loop(input lane_ctrl_t c);
    return c.en_ab & ~c.en_ba_n & ~c.sel_ab & ~c.sel_ba;
  endfunction

endpackage

// File: rtl/strobe_rise.sv
`timescale 1ns/1ps
module strobe_rise (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic prev;

  // Reset presets the history to 1 so a level held across reset is no edge.
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sig;
  end

  assign rise = sig & ~prev;
endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_ctrl_t   ctrl,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         drv_a,
  output logic         drv_b,
  output logic         loop_err
);
  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] a_bus, b_bus;
  logic         rise_ab, rise_ba, loop_c;

  strobe_rise u_rise_ab (.clk(clk), .rst(rst), .sig(cap_ab), .rise(rise_ab));
  strobe_rise u_rise_ba (.clk(clk), .rst(rst), .sig(cap_ba), .rise(rise_ba));

  always_comb begin
    loop_c   = is_loop(ctrl);
    loop_err = ~rst & loop_c;
    drv_b    = ~rst & ctrl.en_ab & ~loop_c;
    drv_a    = ~rst & ~ctrl.en_ba_n & ~loop_c;

    // Resolved bus values. When both sides drive, at most one takes the
    // live path (the other selects its register), so each chain ends.
    if (!drv_a)          a_bus = a_in;
    else if (ctrl.sel_ba) a_bus = reg_b;
    else if (drv_b)      a_bus = reg_a;
    else                 a_bus = b_in;

    if (!drv_b)          b_bus = b_in;
    else if (ctrl.sel_ab) b_bus = reg_a;
    else if (drv_a)      b_bus = reg_b;
    else                 b_bus = a_in;

    a_out = drv_a ? a_bus : '0;
    b_out = drv_b ? b_bus : '0;
  end

  // Capture sees the resolved bus, independent of who drives it.
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (rise_ab) reg_a <= a_bus;
      if (rise_ba) reg_b <= b_bus;
    end
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
`timescale 1ns/1ps
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 2,
  localparam int BW = N * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] a_in,
  output logic [BW-1:0] a_out,
  output logic [BW-1:0] a_oe,
  input  logic [BW-1:0] b_in,
  output logic [BW-1:0] b_out,
  output logic [BW-1:0] b_oe,
  input  logic [N-1:0]  cap_ab,
  input  logic [N-1:0]  cap_ba,
  input  logic [N-1:0]  sel_ab,
  input  logic [N-1:0]  sel_ba,
  input  logic [N-1:0]  en_ab,
  input  logic [N-1:0]  en_ba_n,
  output logic [N-1:0]  loop_err
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    lane_ctrl_t ctrl;
    logic       drv_a, drv_b;

    assign ctrl = '{en_ab: en_ab[i], en_ba_n: en_ba_n[i],
                    sel_ab: sel_ab[i], sel_ba: sel_ba[i]};

    xcvr_lane #(.W(W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .ctrl     (ctrl),
      .cap_ab   (cap_ab[i]),
      .cap_ba   (cap_ba[i]),
      .a_in     (a_in[i*W +: W]),
      .b_in     (b_in[i*W +: W]),
      .a_out    (a_out[i*W +: W]),
      .b_out    (b_out[i*W +: W]),
      .drv_a    (drv_a),
      .drv_b    (drv_b),
      .loop_err (loop_err[i])
    );

    assign a_oe[i*W +: W] = {W{drv_a}};
    assign b_oe[i*W +: W] = {W{drv_b}};
  end
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
`timescale 1ns/1ps
module dual_reg_xcvr_chk #(
  parameter int W = 8,
  parameter int N = 2,
  localparam int BW = N * W
) (
  input logic          clk,
  input logic          rst,
  input logic [BW-1:0] a_out,
  input logic [BW-1:0] a_oe,
  input logic [BW-1:0] b_out,
  input logic [BW-1:0] b_oe,
  input logic [N-1:0]  cap_ab,
  input logic [N-1:0]  sel_ab,
  input logic [N-1:0]  sel_ba,
  input logic [N-1:0]  en_ab,
  input logic [N-1:0]  en_ba_n,
  input logic [N-1:0]  loop_err
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (a_oe == '0 && b_oe == '0 && loop_err == '0)); // R9

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
      (!en_ab[i] && en_ba_n[i]) |-> (a_oe[i*W +: W] == '0 && b_oe[i*W +: W] == '0)); // R5

    AST_LOOP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
      (en_ab[i] && !en_ba_n[i] && !sel_ab[i] && !sel_ba[i]) |-> loop_err[i]); // R8

    AST_LOOP_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      loop_err[i] |-> (a_oe[i*W +: W] == '0 && b_oe[i*W +: W] == '0)); // R8

    AST_B_DRIVEN: assert property (@(posedge clk) disable iff (rst)
      (en_ab[i] && !loop_err[i]) |-> (&b_oe[i*W +: W])); // R3

    AST_A_DRIVEN: assert property (@(posedge clk) disable iff (rst)
      (!en_ba_n[i] && !loop_err[i]) |-> (&a_oe[i*W +: W])); // R3

    AST_STORED_HELD: assert property (@(posedge clk) disable iff (rst)
      (en_ab[i] && sel_ab[i] && $past(en_ab[i]) && $past(sel_ab[i]) && !$past(rst)
       && !($past(cap_ab[i]) && !$past(cap_ab[i], 2)))
      |-> $stable(b_out[i*W +: W])); // R2
  end
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .cap_ab(cap_ab), .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab),
  .en_ba_n(en_ba_n), .loop_err(loop_err)
);

// File: tb/dual_reg_xcvr_test.sv
`timescale 1ns/1ps
module dual_reg_xcvr_test;
  localparam int W  = 8;
  localparam int N  = 2;
  localparam int BW = N * W;

  // Row layout: [21]en_ab [20]en_ba_n [19]sel_ab [18]sel_ba [17]cap_ab [16]cap_ba [15:8]A [7:0]B
  typedef logic [21:0] row_t;
  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    {6'b010011, 8'h11, 8'h22},  // isolate, load both          R5 R1
    {6'b110011, 8'h33, 8'h5A},  // live A->B, store A in both   R6
    {6'b111000, 8'h44, 8'h66},  // stored A->B, no strobe       R2 R4
    {6'b000010, 8'h77, 8'h55},  // live B->A, store B into A    R6
    {6'b000101, 8'h88, 8'h99},  // stored B->A, load B input    R4
    {6'b101111, 8'hAA, 8'hBB},  // both stored, swap            R7 R11
    {6'b100011, 8'hC3, 8'h3C},  // loop setting                 R8
    {6'b101001, 8'h01, 8'h02},  // B gets stored A, A live      R6
    {6'b100110, 8'hF0, 8'h0F},  // A gets stored B, B live      R6
    {6'b011110, 8'hE7, 8'h7E},  // isolate with selects high    R5
    {6'b111101, 8'h12, 8'h34},  // stored A driven, B loads it  R6
    {6'b000011, 8'h56, 8'h78}   // live B->A, load both         R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [BW-1:0] a_out, a_oe, b_out, b_oe;
  logic [N-1:0]  cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [N-1:0]  en_ab = '0, en_ba_n = '1, loop_err;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] m_ra [N];
  logic [W-1:0] m_rb [N];

  always #2.5 clk = ~clk;

  dual_reg_xcvr #(.W(W), .N(N)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .loop_err(loop_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected behaviour of one channel from the requirements.
  task automatic model(input int c, output logic da, output logic db, output logic er,
                       output logic [W-1:0] abus, output logic [W-1:0] bbus);
    logic lp;
    lp   = en_ab[c] && !en_ba_n[c] && !sel_ab[c] && !sel_ba[c];
    er   = !rst && lp;
    da   = !rst && !en_ba_n[c] && !lp;
    db   = !rst && en_ab[c] && !lp;
    abus = a_in[c*W +: W];
    bbus = b_in[c*W +: W];
    if (da) abus = sel_ba[c] ? m_rb[c] : (db ? m_ra[c] : b_in[c*W +: W]);
    if (db) bbus = sel_ab[c] ? m_ra[c] : (da ? m_rb[c] : a_in[c*W +: W]);
  endtask

  task automatic check_chan(input int c, input string t_out, input string t_oe);
    logic da, db, er;
    logic [W-1:0] ab, bb;
    model(c, da, db, er, ab, bb);
    chk(t_out, 32'(a_out[c*W +: W]), 32'(da ? ab : '0));
    chk(t_out, 32'(b_out[c*W +: W]), 32'(db ? bb : '0));
    chk(t_oe,  32'(a_oe[c*W +: W]),  32'({W{da}}));
    chk(t_oe,  32'(b_oe[c*W +: W]),  32'({W{db}}));
    chk("R8",  32'(loop_err[c]),     32'(er));
  endtask

  task automatic set_ctrl(input int c, input logic [3:0] k);
    {en_ab[c], en_ba_n[c], sel_ab[c], sel_ba[c]} = k;
  endtask

  function automatic string out_tag(input row_t r);
    if (r[21] && !r[20] && !r[19] && !r[18]) return "R8";
    if (!r[21] && r[20])                     return "R5";
    if (r[21] && !r[20] && r[19] && r[18])   return "R7";
    return "R4";
  endfunction

  function automatic string cap_tag(input row_t r);
    logic lp;
    lp = r[21] && !r[20] && !r[19] && !r[18];
    if (r[17] && r[16] && r[21] && !r[20] && r[19] && r[18]) return "R11";
    if ((r[16] && r[21] && !lp) || (r[17] && !r[20] && !lp)) return "R6";
    if (r[17] || r[16])                                       return "R1";
    return "R2";
  endfunction

  task automatic run_table(input int c);
    int o;
    o = 1 - c;
    set_ctrl(o, 4'b1110);  // other channel: stored A onto B
    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      logic da, db, er;
      logic [W-1:0] ab, bb;
      r = ROWS[i];
      @(negedge clk);
      set_ctrl(c, r[21:18]);
      a_in[c*W +: W] = r[15:8];
      b_in[c*W +: W] = r[7:0];
      a_in[o*W +: W] = ~r[15:8];
      b_in[o*W +: W] = ~r[7:0];
      cap_ab[c] = 1'b0; cap_ba[c] = 1'b0;
      #1;
      check_chan(c, out_tag(r), (out_tag(r) == "R4" || out_tag(r) == "R7") ? "R3" : out_tag(r));
      check_chan(o, "R10", "R10");
      @(negedge clk);
      model(c, da, db, er, ab, bb);
      cap_ab[c] = r[17];
      cap_ba[c] = r[16];
      @(negedge clk);
      if (r[17]) m_ra[c] = ab;
      if (r[16]) m_rb[c] = bb;
      cap_ab[c] = 1'b0; cap_ba[c] = 1'b0;
      set_ctrl(c, 4'b1011);  // readback: both stored words on the outputs
      #1;
      check_chan(c, cap_tag(r), "R3");
      check_chan(o, "R10", "R10");
    end
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin m_ra[c] = '0; m_rb[c] = '0; end
    // Reset: controls request drive on ch0 and the loop on ch1, strobes pulse.
    set_ctrl(0, 4'b1011);
    set_ctrl(1, 4'b1000);
    a_in = 16'hA5A5; b_in = 16'h5A5A;
    @(negedge clk); cap_ab = '1; cap_ba = '1;
    @(negedge clk); cap_ab = '0; cap_ba = '0;
    @(negedge clk); #1;
    chk("R9", 32'(a_oe), 32'h0);
    chk("R9", 32'(b_oe), 32'h0);
    chk("R9", 32'(loop_err), 32'h0);
    rst = 1'b0;
    set_ctrl(1, 4'b1011);
    #1;
    check_chan(0, "R9", "R3");
    check_chan(1, "R9", "R3");

    // Strobe held high from reset release: no edge, no load.
    @(negedge clk); cap_ab[0] = 1'b1; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check_chan(0, "R1", "R3");
    cap_ab[0] = 1'b0;

    run_table(0);
    run_table(1);

    // Reset in the middle of operation clears stored words.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < N; c++) begin m_ra[c] = '0; m_rb[c] = '0; set_ctrl(c, 4'b1011); end
    #1;
    check_chan(0, "R9", "R3");
    check_chan(1, "R9", "R3");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule